// File: doc/BRIEF.md
# Synchronous Host Bus Register Interface

This block is a clocked slave that sits between a host processor bus and a bank of byte-wide configuration registers. It runs on the host clock. The host drives an address, an active-low chip select, an active-low write strobe and a read/not-write direction line. The 8-bit bidirectional data bus appears at the block edge as its pad-side parts: an input byte, an output byte and an output enable. The pad ring combines them into the shared bus. The block drives the bus only for reads.

A cycle begins on the rising edge where chip select is low and either the direction line is high (a read) or the write strobe is low with the direction line low (a write). Write data enters the addressed register on that same edge. Read data is captured on that edge and driven from it onward. After `WAIT_STATES` further edges, the active-high ready output rises for exactly one clock. The host stretches the cycle until it samples ready high, then releases chip select. An address-latch-enable input is present for pin compatibility and has no effect.

The controller is a four-state machine. IDLE waits for a cycle start and moves to WAIT (when `WAIT_STATES` > 0) or straight to ACK. WAIT counts down the wait states and then moves to ACK. ACK is the single-clock ready pulse and moves to HOLD. HOLD waits for chip select to go high. From WAIT, ACK and HOLD, chip select sampled high returns the machine to IDLE.

Top module: `hostbus_regif`

## Requirements
- R1: A write updates the addressed register (visible on `cfg_q`, byte i at bits [8i+7:8i]) on the same rising edge that first samples `cs_n`, `we_n` and `rd_wr_n` all low in IDLE, before ready rises.
- R2: No register changes unless `cs_n`, `we_n` and `rd_wr_n` are all sampled low at the start of a cycle; with `we_n` high and `rd_wr_n` low, no cycle starts and ready stays low.
- R3: A read (`cs_n` low, `rd_wr_n` high) drives `bus_oe` high and `bus_dout` with the addressed register's value from the edge after the start edge, no later than the ready edge.
- R4: Ready rises exactly `WAIT_STATES` clocks after the first clock on which the block reacts to the start edge; with the default of 2, two low samples of ready precede the high one.
- R5: Ready stays high for exactly one clock per cycle, then returns low.
- R6: While chip select stays low after a ready pulse, no second ready pulse and no second write occur.
- R7: When `cs_n` is sampled high, `bus_oe` and `rdy` are both low after that edge, including when the cycle is abandoned during wait states.
- R8: Addresses at or above `NUM_REGS` (16 by default) are unmapped: writes there change no register, reads there return 0x00, and both end with a normal ready pulse.
- R9: The `ale` input has no effect on any output.
- R10: Synchronous active-high `rst` clears every register to 0x00 and drives `rdy` and `bus_oe` low.
- R11: `bus_oe` stays low throughout write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host processor clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| rd_wr_n | input | 1 | Direction: 1 = read, 0 = write |
| ale | input | 1 | Address latch enable, ignored |
| addr | input | ADDR_W (6) | Register address |
| bus_din | input | 8 | Data bus, pad input side |
| bus_dout | output | 8 | Data bus, pad output side |
| bus_oe | output | 1 | Data bus output enable (block drives the bus) |
| rdy | output | 1 | Ready, active high, one clock per cycle |
| cfg_q | output | NUM_REGS*8 (128) | Current contents of all registers |

## Verification
A table of writes and reads is applied. It covers the lowest, highest and interior mapped addresses, unmapped addresses and both levels of `ale`. Read-back against a bench model shows whether data lands in the right register and whether unmapped accesses leak into the bank. Directed patterns follow. A strobe without the full write qualification separates real writes from partial ones. Chip select held low past ready exposes duplicate pulses or duplicate writes. Chip select released during wait states separates abort handling from normal completion. A reset after traffic checks that the bank clears.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_HOLD = 2'd3
    } hbr_state_e;

endpackage

// File: rtl/hbr_ctrl.sv
module hbr_ctrl
    import hbr_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic we_n,
    input  logic rd_wr_n,
    output logic wr_en,
    output logic rd_cap,
    output logic rdy,
    output logic oe
);

    localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = (WAIT_STATES > 0) ? CNT_W'(WAIT_STATES - 1) : '0;

    hbr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic is_read_q, is_read_d;
    logic start;

    assign start  = !cs_n && (rd_wr_n || !we_n);
    assign wr_en  = (state_q == ST_IDLE) && !cs_n && !we_n && !rd_wr_n;
    assign rd_cap = (state_q == ST_IDLE) && !cs_n && rd_wr_n;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        is_read_d = is_read_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    is_read_d = rd_wr_n;
                    cnt_d     = CNT_LOAD;
                    state_d   = (WAIT_STATES > 0) ? ST_WAIT : ST_ACK;
                end
            end
            ST_WAIT: begin
                if (cs_n) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = ST_ACK;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACK: begin
                state_d = cs_n ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            is_read_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            is_read_q <= is_read_d;
        end
    end

    // registered outputs, so ready only moves on rising edges
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy <= 1'b0;
            oe  <= 1'b0;
        end else begin
            rdy <= (state_d == ST_ACK);
            oe  <= (state_d != ST_IDLE) && is_read_d;
        end
    end

    AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) rdy |=> !rdy); // R5
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst) cs_n |=> (!rdy && !oe)); // R7
    AST_RDY_NEEDS_CS: assert property (@(posedge clk) disable iff (rst) rdy |-> $past(!cs_n)); // R6
    AST_OE_ON_READ: assert property (@(posedge clk) disable iff (rst) $rose(oe) |-> $past(rd_wr_n)); // R3
    AST_NO_OE_WRITE: assert property (@(posedge clk) disable iff (rst) wr_en |=> !oe); // R11

endmodule

// File: rtl/hbr_regbank.sv
module hbr_regbank #(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_cap,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata_q,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic       mapped;
    logic [7:0] rd_mux;
    logic [7:0] bank [NUM_REGS];

    assign mapped = (32'(addr) < NUM_REGS);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= 8'h00;
            end else if (wr_en && mapped && (IDX_W'(addr) == IDX_W'(i))) begin
                bank[i] <= wdata;
            end
        end
        assign regs_flat[i*8 +: 8] = bank[i];
    end

    always_comb begin
        rd_mux = 8'h00;
        if (mapped) begin
            rd_mux = bank[IDX_W'(addr)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= 8'h00;
        end else if (rd_cap) begin
            rdata_q <= rd_mux;
        end
    end

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_cap && !mapped) |=> (rdata_q == 8'h00)); // R8
    AST_UNMAPPED_WRITE_KEEP: assert property (@(posedge clk) disable iff (rst) (wr_en && !mapped) |=> $stable(regs_flat)); // R8
    AST_IDLE_BANK_STABLE: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(regs_flat)); // R2

endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
    parameter int NUM_REGS    = 16,
    parameter int ADDR_W      = 6,
    parameter int WAIT_STATES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  we_n,
    input  logic                  rd_wr_n,
    input  logic                  ale,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            bus_din,
    output logic [7:0]            bus_dout,
    output logic                  bus_oe,
    output logic                  rdy,
    output logic [NUM_REGS*8-1:0] cfg_q
);

    logic wr_en;
    logic rd_cap;
    logic ale_unused;

    // address latch enable has no role in this synchronous mode
    assign ale_unused = ale;

    hbr_ctrl #(
        .WAIT_STATES(WAIT_STATES)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .rd_wr_n (rd_wr_n),
        .wr_en   (wr_en),
        .rd_cap  (rd_cap),
        .rdy     (rdy),
        .oe      (bus_oe)
    );

    hbr_regbank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_cap    (rd_cap),
        .addr      (addr),
        .wdata     (bus_din),
        .rdata_q   (bus_dout),
        .regs_flat (cfg_q)
    );

    AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (rst) wr_en |-> (!cs_n && !we_n && !rd_wr_n)); // R1
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!rdy && !bus_oe && (cfg_q == '0))); // R10

endmodule

// File: tb/tb_hostbus_regif.sv
module tb_hostbus_regif;

    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 16;
    localparam int AW    = 6;
    localparam int WAITS = 2;
    localparam int NVEC  = 12;

    // vector: {write, ale, addr[5:0], data[7:0]}; for reads data is the expected value
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 6'd0,  8'hA5},
        {1'b1, 1'b1, 6'd5,  8'h3C},
        {1'b1, 1'b0, 6'd15, 8'hFF},
        {1'b1, 1'b1, 6'd20, 8'h77},
        {1'b0, 1'b0, 6'd0,  8'hA5},
        {1'b0, 1'b1, 6'd5,  8'h3C},
        {1'b0, 1'b0, 6'd15, 8'hFF},
        {1'b0, 1'b1, 6'd20, 8'h00},
        {1'b0, 1'b0, 6'd3,  8'h00},
        {1'b1, 1'b0, 6'd5,  8'h81},
        {1'b0, 1'b0, 6'd5,  8'h81},
        {1'b0, 1'b1, 6'd63, 8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, we_n = 1'b1, rd_wr_n = 1'b1, ale = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic bus_oe, rdy;
    logic [NREG*8-1:0] cfg_q;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [NREG];
    logic [7:0] got_data;
    int got_waits;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_regif #(.NUM_REGS(NREG), .ADDR_W(AW), .WAIT_STATES(WAITS)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .rd_wr_n(rd_wr_n),
        .ale(ale), .addr(addr), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .rdy(rdy), .cfg_q(cfg_q)
    );

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one complete host cycle, chip select released after ready is seen
    task automatic host_cycle(input bit wr, input bit al, input logic [AW-1:0] a, input logic [7:0] wd);
        @(negedge clk);
        cs_n = 1'b0; rd_wr_n = !wr; we_n = !wr; addr = a; bus_din = wd; ale = al;
        got_waits = 0;
        @(negedge clk);
        if (wr && a < NREG) chk(cfg_q[a*8 +: 8] == wd, "R1", cfg_q[a*8 +: 8], wd);
        while (!rdy && got_waits < 40) begin
            got_waits++;
            chk(bus_oe == !wr, wr ? "R11" : "R3", bus_oe, !wr);
            @(negedge clk);
        end
        got_data = bus_dout;
        chk(bus_oe == !wr, wr ? "R11" : "R3", bus_oe, !wr);
        cs_n = 1'b1; we_n = 1'b1; ale = 1'b0;
        @(negedge clk);
        chk(!rdy && !bus_oe, "R7", {rdy, bus_oe}, 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rdy && !bus_oe && cfg_q == '0, "R10", {rdy, bus_oe, cfg_q}, 0);

        // table of vectors
        for (int v = 0; v < NVEC; v++) begin
            logic wr, al;
            logic [AW-1:0] a;
            logic [7:0] d;
            {wr, al, a, d} = VEC[v];
            host_cycle(wr, al, a, d);
            chk(got_waits == WAITS, "R4", got_waits, WAITS);
            if (wr) begin
                if (a < NREG) model[a] = d;
                chk(cfg_q == model_flat(), a < NREG ? "R1" : "R8", cfg_q, model_flat());
            end else begin
                chk(got_data == d, a < NREG ? "R3" : "R8", got_data, d);
            end
        end

        // R2: write strobe high with direction low: no cycle, no change
        @(negedge clk);
        cs_n = 1'b0; rd_wr_n = 1'b0; we_n = 1'b1; addr = 6'd2; bus_din = 8'h5A;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!rdy && cfg_q == model_flat(), "R2", {rdy, cfg_q}, {1'b0, model_flat()});
        end
        cs_n = 1'b1; we_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rdy && cfg_q == model_flat(), "R2", {rdy, cfg_q}, {1'b0, model_flat()});
        we_n = 1'b1;

        // R9: ale toggling while idle changes nothing
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ale = ~ale;
        end
        @(negedge clk);
        ale = 1'b0;
        chk(!rdy && !bus_oe && cfg_q == model_flat(), "R9", {rdy, bus_oe, cfg_q}, {2'b00, model_flat()});

        // R5/R6: chip select held low long after ready
        begin
            int pulses;
            pulses = 0;
            @(negedge clk);
            cs_n = 1'b0; rd_wr_n = 1'b0; we_n = 1'b0; addr = 6'd9; bus_din = 8'h42;
            model[9] = 8'h42;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (rdy) pulses++;
                if (k == 5) bus_din = 8'hEE;
            end
            chk(pulses == 1, "R5", pulses, 1);
            chk(cfg_q == model_flat(), "R6", cfg_q, model_flat());
            cs_n = 1'b1; we_n = 1'b1;
            @(negedge clk);
        end

        // R7: abandoned read during wait states
        @(negedge clk);
        cs_n = 1'b0; rd_wr_n = 1'b1; addr = 6'd9;
        @(negedge clk);
        chk(bus_oe && !rdy, "R3", {bus_oe, rdy}, 2'b10);
        cs_n = 1'b1;
        @(negedge clk);
        chk(!bus_oe && !rdy, "R7", {bus_oe, rdy}, 2'b00);
        begin
            int late;
            late = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (rdy) late++;
            end
            chk(late == 0, "R7", late, 0);
        end

        // R10: reset after traffic clears the bank
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cfg_q == '0 && !rdy && !bus_oe, "R10", cfg_q, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule